// File: doc/BRIEF.md
# Sound Generator Register Write Front End

This block takes byte writes meant for a four-channel programmable sound generator and turns them into a bank of eight registers. The bank holds three 10-bit tone periods, four 4-bit attenuation levels and one noise control register. A byte with bit 7 set is a latch byte. It names a register and loads that register's low bits. A byte with bit 7 clear is a data byte and goes to the register named by the most recent latch. The tone counters, the noise shift register and the mixer sit downstream and read the register outputs. They also see a one-cycle strobe that tells the noise generator to reload its seed.

Two build-time flags pick the variant. `STRICT_DATA` makes the block discard data bytes aimed at the attenuation registers or the noise register. In that variant the noise reseed strobe fires only when a latch write flips the noise mode bit. `CONSOLE_RESET` selects register 3 at reset, resets every attenuation to full scale (0xF) and treats a tone period of 0 as 0x400.

Top module: `psg_wr_front`

## Requirements
- R1: A write with `wr_data[7]`=1 selects register `wr_data[6:4]`, and `last_reg` shows that index after the next clock edge. Bits 3:0 replace bits 3:0 of a tone register, or the whole value of an attenuation register. Bits 2:0 replace the noise register, where bit 2 is the mode and bits 1:0 are the rate. Register map: 0, 2 and 4 are tones 0 to 2; 1, 3, 5 and 7 are attenuations 0 to 3; 6 is noise.
- R2: A write with `wr_data[7]`=0 goes to `last_reg` and leaves `last_reg` unchanged. For a tone register, bits 5:0 go to period bits 9:4 and the low nibble is kept. For an attenuation register, bits 3:0 replace the level. For the noise register, bits 2:0 replace the value.
- R3: With `STRICT_DATA`=1, a data byte is discarded while `last_reg` is 1, 3, 5, 6 or 7. No output changes and no strobe is issued.
- R4: With `STRICT_DATA`=0, every accepted write to register 6, whether a latch or a data byte, raises `lfsr_reset` for exactly the cycle after the write edge.
- R5: With `STRICT_DATA`=1, `lfsr_reset` pulses after a latch write to register 6 only when the new bit 2 differs from the stored mode bit. A data byte never causes a pulse.
- R6: `noise_rate` and `noise_mode` show noise register bits 1:0 and bit 2. `noise_period` is 32 << rate for rates 0 to 2. For rate 3 it is twice the effective tone 2 period.
- R7: `tone_period` carries three 11-bit effective periods, with tone 0 in bits 10:0. A stored value of 0 reads as 0x400 when `CONSOLE_RESET`=1 and as 0 otherwise.
- R8: After reset, tone and noise registers are 0. With `CONSOLE_RESET`=1, attenuations are 0xF and `last_reg` is 3. Otherwise attenuations are 0 and `last_reg` is 0.
- R9: While `wr_en` is 0, no register changes and `lfsr_reset` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Latch or data byte |
| last_reg | output | 3 | Index of the last latched register |
| tone_period | output | 33 | Three 11-bit effective tone periods, tone 0 lowest |
| att_level | output | 16 | Four 4-bit attenuations, channel 0 lowest |
| noise_rate | output | 2 | Noise rate selection |
| noise_mode | output | 1 | Noise mode bit |
| noise_period | output | 12 | Derived noise period |
| lfsr_reset | output | 1 | One-cycle noise reseed strobe |

## Verification
The same stream goes to three copies of the block: a normal build, a strict build and a console build. Differences between their outputs show which variant behaviour is being tested.

The directed part of the stream covers several cases:
- data bytes before any latch, which shows the reset selection;
- latch-then-data pairs on a tone register, which shows the two halves being merged;
- data bytes after attenuation and noise latches, which shows the strict filter at work;
- repeated noise latches with and without a mode change, which shows the two reseed rules apart;
- a zero tone 2 period under rate 3, which shows the zero-period handling.

A long pseudo-random byte stream with idle gaps follows. It reaches register and selection combinations the directed part does not.

// File: rtl/psg_wr_pkg.sv
package psg_wr_pkg;
  localparam int TONE_W    = 10;
  localparam int ATT_W     = 4;
  localparam int EFF_W     = TONE_W + 1;
  localparam int NPER_W    = EFF_W + 1;
  localparam int IDX_W     = 3;
  localparam int HI_W      = TONE_W - 4;
  localparam int NOISE_IDX = 6;
  localparam int NUM_TONE  = 3;
  localparam int NUM_ATT   = 4;

  typedef enum logic [1:0] {RK_TONE, RK_ATT, RK_NOISE} reg_kind_e;

  function automatic reg_kind_e kind_of(input logic [IDX_W-1:0] idx);
    if (idx[0]) return RK_ATT;
    if (idx == IDX_W'(NOISE_IDX)) return RK_NOISE;
    return RK_TONE;
  endfunction

  function automatic logic drops_data(input logic [IDX_W-1:0] idx, input bit strict);
    return strict && (kind_of(idx) != RK_TONE);
  endfunction

  function automatic logic [EFF_W-1:0] eff_period(input logic [TONE_W-1:0] raw, input bit console);
    if (raw != '0) return {1'b0, raw};
    return console ? (EFF_W'(1) << TONE_W) : '0;
  endfunction

  function automatic logic [NPER_W-1:0] noise_len(input logic [1:0] rate,
                                                   input logic [EFF_W-1:0] t2,
                                                   input int base);
    if (rate == 2'd3) return {t2, 1'b0};
    return NPER_W'(1) << (base + int'(rate));
  endfunction
endpackage

// File: rtl/psg_wr_decode.sv
module psg_wr_decode
  import psg_wr_pkg::*;
#(
  parameter bit STRICT_DATA = 1'b0
) (
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] sel_q,
  output logic             is_latch,
  output logic [IDX_W-1:0] tgt_idx,
  output logic             wr_accept
);
  assign is_latch  = wr_data[7];
  assign tgt_idx   = is_latch ? wr_data[6:4] : sel_q;
  assign wr_accept = wr_en && (is_latch || !drops_data(sel_q, STRICT_DATA));
endmodule

// File: rtl/psg_tone_slot.sv
module psg_tone_slot
  import psg_wr_pkg::*;
#(
  parameter bit CONSOLE_RESET = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             is_latch,
  input  logic [7:0]       din,
  output logic [EFF_W-1:0] period_o
);
  logic [TONE_W-1:0] raw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (hit) begin
      if (is_latch) raw_q[3:0] <= din[3:0];
      else          raw_q[TONE_W-1:4] <= din[HI_W-1:0];
    end
  end

  assign period_o = eff_period(raw_q, CONSOLE_RESET);
endmodule

// File: rtl/psg_att_slot.sv
module psg_att_slot
  import psg_wr_pkg::*;
#(
  parameter bit CONSOLE_RESET = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [7:0]       din,
  output logic [ATT_W-1:0] level_o
);
  localparam logic [ATT_W-1:0] RST_LVL = CONSOLE_RESET ? '1 : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)   level_o <= RST_LVL;
    else if (hit) level_o <= din[ATT_W-1:0];
  end
endmodule

// File: rtl/psg_noise_ctl.sv
module psg_noise_ctl
  import psg_wr_pkg::*;
#(
  parameter bit STRICT_DATA = 1'b0,
  parameter int BASE_SHIFT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              is_latch,
  input  logic [7:0]        din,
  input  logic [EFF_W-1:0]  tone2_eff,
  output logic [1:0]        rate_o,
  output logic              mode_o,
  output logic [NPER_W-1:0] period_o,
  output logic              lfsr_reset_o
);
  logic [2:0] ctl_q;
  logic       mode_flip;
  logic       fire;

  assign mode_flip = din[2] != ctl_q[2];
  assign fire      = hit && (STRICT_DATA ? (is_latch && mode_flip) : 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q        <= '0;
      lfsr_reset_o <= 1'b0;
    end else begin
      lfsr_reset_o <= fire;
      if (hit) ctl_q <= din[2:0];
    end
  end

  assign rate_o   = ctl_q[1:0];
  assign mode_o   = ctl_q[2];
  assign period_o = noise_len(ctl_q[1:0], tone2_eff, BASE_SHIFT);
endmodule

// File: rtl/psg_wr_front.sv
module psg_wr_front
  import psg_wr_pkg::*;
#(
  parameter bit STRICT_DATA   = 1'b0,
  parameter bit CONSOLE_RESET = 1'b0,
  parameter int BASE_SHIFT    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [7:0]                wr_data,
  output logic [IDX_W-1:0]          last_reg,
  output logic [NUM_TONE*EFF_W-1:0] tone_period,
  output logic [NUM_ATT*ATT_W-1:0]  att_level,
  output logic [1:0]                noise_rate,
  output logic                      noise_mode,
  output logic [NPER_W-1:0]         noise_period,
  output logic                      lfsr_reset
);
  localparam logic [IDX_W-1:0] RST_SEL = CONSOLE_RESET ? IDX_W'(3) : '0;

  logic             is_latch;
  logic [IDX_W-1:0] tgt_idx;
  logic             wr_accept;
  logic [IDX_W-1:0] sel_q;

  psg_wr_decode #(.STRICT_DATA(STRICT_DATA)) u_dec (
    .wr_en(wr_en), .wr_data(wr_data), .sel_q(sel_q),
    .is_latch(is_latch), .tgt_idx(tgt_idx), .wr_accept(wr_accept)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                  sel_q <= RST_SEL;
    else if (wr_en && is_latch)  sel_q <= wr_data[6:4];
  end
  assign last_reg = sel_q;

  for (genvar t = 0; t < NUM_TONE; t++) begin : g_tone
    psg_tone_slot #(.CONSOLE_RESET(CONSOLE_RESET)) u_tone (
      .clk(clk), .rst_n(rst_n),
      .hit(wr_accept && (tgt_idx == IDX_W'(2*t))),
      .is_latch(is_latch), .din(wr_data),
      .period_o(tone_period[t*EFF_W +: EFF_W])
    );
  end

  for (genvar a = 0; a < NUM_ATT; a++) begin : g_att
    psg_att_slot #(.CONSOLE_RESET(CONSOLE_RESET)) u_att (
      .clk(clk), .rst_n(rst_n),
      .hit(wr_accept && (tgt_idx == IDX_W'(2*a+1))),
      .din(wr_data),
      .level_o(att_level[a*ATT_W +: ATT_W])
    );
  end

  psg_noise_ctl #(.STRICT_DATA(STRICT_DATA), .BASE_SHIFT(BASE_SHIFT)) u_noise (
    .clk(clk), .rst_n(rst_n),
    .hit(wr_accept && (tgt_idx == IDX_W'(NOISE_IDX))),
    .is_latch(is_latch), .din(wr_data),
    .tone2_eff(tone_period[2*EFF_W +: EFF_W]),
    .rate_o(noise_rate), .mode_o(noise_mode),
    .period_o(noise_period), .lfsr_reset_o(lfsr_reset)
  );
endmodule

// File: rtl/psg_wr_chk.sv
module psg_wr_chk
  import psg_wr_pkg::*;
#(
  parameter bit STRICT_DATA   = 1'b0,
  parameter bit CONSOLE_RESET = 1'b0
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [7:0]                wr_data,
  input logic                      wr_accept,
  input logic [IDX_W-1:0]          last_reg,
  input logic [NUM_TONE*EFF_W-1:0] tone_period,
  input logic [NUM_ATT*ATT_W-1:0]  att_level,
  input logic [1:0]                noise_rate,
  input logic                      noise_mode,
  input logic [NPER_W-1:0]         noise_period,
  input logic                      lfsr_reset
);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(tone_period) && $stable(att_level) && $stable(noise_rate)
               && $stable(noise_mode) && !lfsr_reset);

  // R1
  latch_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[7] |=> last_reg == $past(wr_data[6:4]));

  // R2
  data_keeps_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[7] |=> $stable(last_reg));

  // R4
  reseed_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_reset |-> $past(wr_en) &&
      ($past(wr_data[7]) ? ($past(wr_data[6:4]) == 3'd6) : ($past(last_reg) == 3'd6)));

  // R6
  noise_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    noise_rate != 2'd3 |-> $onehot(noise_period));

  if (STRICT_DATA) begin : g_strict
    // R3
    drop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_data[7] && (last_reg[0] || last_reg == 3'd6) |=>
        $stable(tone_period) && $stable(att_level) && $stable(noise_rate)
        && $stable(noise_mode) && !lfsr_reset);
    // R5
    mode_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_reset |-> noise_mode != $past(noise_mode));
    // R3
    accept_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_accept && !wr_data[7] |-> !last_reg[0] && last_reg != 3'd6);
  end

  if (CONSOLE_RESET) begin : g_console
    for (genvar t = 0; t < NUM_TONE; t++) begin : g_t
      // R7
      zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tone_period[t*EFF_W +: EFF_W] != '0);
    end
  end
endmodule

bind psg_wr_front psg_wr_chk #(.STRICT_DATA(STRICT_DATA), .CONSOLE_RESET(CONSOLE_RESET)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_accept(wr_accept),
  .last_reg(last_reg), .tone_period(tone_period), .att_level(att_level),
  .noise_rate(noise_rate), .noise_mode(noise_mode), .noise_period(noise_period),
  .lfsr_reset(lfsr_reset)
);

// File: tb/sim_psg_wr_front.sv
module sim_psg_wr_front;
  localparam int CLK_PERIOD = 10;
  localparam int NINST = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;

  logic [2:0]  lr_w [NINST];
  logic [32:0] tp_w [NINST];
  logic [15:0] al_w [NINST];
  logic [1:0]  nr_w [NINST];
  logic        nm_w [NINST];
  logic [11:0] np_w [NINST];
  logic        ls_w [NINST];

  int nvec = 0;
  int nbad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // u0: normal, u1: strict, u2: console
  psg_wr_front #(.STRICT_DATA(1'b0), .CONSOLE_RESET(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .last_reg(lr_w[0]),
    .tone_period(tp_w[0]), .att_level(al_w[0]), .noise_rate(nr_w[0]), .noise_mode(nm_w[0]),
    .noise_period(np_w[0]), .lfsr_reset(ls_w[0]));
  psg_wr_front #(.STRICT_DATA(1'b1), .CONSOLE_RESET(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .last_reg(lr_w[1]),
    .tone_period(tp_w[1]), .att_level(al_w[1]), .noise_rate(nr_w[1]), .noise_mode(nm_w[1]),
    .noise_period(np_w[1]), .lfsr_reset(ls_w[1]));
  psg_wr_front #(.STRICT_DATA(1'b0), .CONSOLE_RESET(1'b1)) u2 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .last_reg(lr_w[2]),
    .tone_period(tp_w[2]), .att_level(al_w[2]), .noise_rate(nr_w[2]), .noise_mode(nm_w[2]),
    .noise_period(np_w[2]), .lfsr_reset(ls_w[2]));

  // Behavioural reference: plain integer register file per instance
  int m_reg [NINST][8];
  int m_sel [NINST];
  int m_pulse [NINST];
  int stim [$];

  function automatic bit is_strict(int k);  return k == 1; endfunction
  function automatic bit is_console(int k); return k == 2; endfunction

  function automatic int eff(int k, int raw);
    if (raw == 0) return is_console(k) ? 1024 : 0;
    return raw;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < NINST; k++) begin
      for (int r = 0; r < 8; r++) m_reg[k][r] = (r % 2 == 1 && is_console(k)) ? 15 : 0;
      m_sel[k] = is_console(k) ? 3 : 0;
      m_pulse[k] = 0;
    end
  endtask

  task automatic model_write(int b);
    for (int k = 0; k < NINST; k++) begin
      int r;
      int lo;
      lo = b % 16;
      if (b >= 128) begin
        r = (b / 16) % 8;
        m_sel[k] = r;
        if (r == 6) begin
          if (!is_strict(k) || ((m_reg[k][6] / 4) % 2 != (lo / 4) % 2)) m_pulse[k] = 1;
          m_reg[k][6] = lo % 8;
        end else if (r % 2 == 1) m_reg[k][r] = lo;
        else m_reg[k][r] = (m_reg[k][r] / 16) * 16 + lo;
      end else begin
        r = m_sel[k];
        if (is_strict(k) && (r % 2 == 1 || r == 6)) continue;
        if (r == 6) begin
          m_reg[k][6] = b % 8;
          m_pulse[k] = 1;
        end else if (r % 2 == 1) m_reg[k][r] = lo;
        else m_reg[k][r] = (b % 64) * 16 + m_reg[k][r] % 16;
      end
    end
  endtask

  task automatic chk(string req, int k, string what, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s inst%0d %s actual=%0h expected=%0h", req, k, what, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int k = 0; k < NINST; k++) begin
      int rate;
      int np;
      chk("R1 R8", k, "last_reg", int'(lr_w[k]), m_sel[k]);
      for (int t = 0; t < 3; t++)
        chk("R1 R2 R7 R9", k, $sformatf("tone%0d", t), int'(tp_w[k][t*11 +: 11]), eff(k, m_reg[k][2*t]));
      for (int a = 0; a < 4; a++)
        chk("R2 R3 R8 R9", k, $sformatf("att%0d", a), int'(al_w[k][a*4 +: 4]), m_reg[k][2*a+1]);
      rate = m_reg[k][6] % 4;
      chk("R3 R6", k, "noise_rate", int'(nr_w[k]), rate);
      chk("R3 R6", k, "noise_mode", int'(nm_w[k]), m_reg[k][6] / 4);
      np = (rate == 3) ? 2 * eff(k, m_reg[k][4]) : (32 << rate);
      chk("R6", k, "noise_period", int'(np_w[k]), np);
      chk("R4 R5", k, "lfsr_reset", int'(ls_w[k]), m_pulse[k]);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin : main
    int seed;
    int b;
    // Directed: data before any latch, tone merge, strict filtering, reseed rules, zero period
    stim = '{8'h2A, 8'h8A, 8'h15, -1, 8'h3F, 8'h9C, 8'h07, 8'hA0, 8'h00,
             8'hE3, 8'hE7, 8'hE6, 8'h04, 8'h01, 8'hE0, 8'hE1, 8'hE2, -1,
             8'hBF, 8'h02, 8'hDF, 8'h09, 8'hFF, 8'h05, 8'hC3, 8'h2B, 8'hE3, 8'hE7};
    seed = 12345;
    for (int i = 0; i < 600; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
      b = (seed >> 8) & 8'hFF;
      if (((seed >> 20) & 7) == 0) stim.push_back(-1);
      else stim.push_back(b);
    end

    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    while (stim.size() > 0) begin
      int item;
      @(negedge clk);
      compare_all();
      item = stim.pop_front();
      for (int k = 0; k < NINST; k++) m_pulse[k] = 0;
      if (item < 0) begin
        wr_en = 1'b0;
        wr_data = 8'h00;
      end else begin
        wr_en = 1'b1;
        wr_data = 8'(item);
        model_write(item);
      end
    end
    @(negedge clk);
    compare_all();
    wr_en = 1'b0;
    for (int k = 0; k < NINST; k++) m_pulse[k] = 0;
    @(negedge clk);
    compare_all();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule